// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Vector Encoder

This block collects interrupt requests from up to `NCHILD` groups of `NSRC` sources. Each group has its own controller instance. Every source passes through a two-flop synchronizer. It is then qualified by a per-source polarity and a per-source trigger mode (level or edge), and latched into a sticky status register. Software clears a status bit by writing a 1 to it. An enable register gates the status into a masked view. A per-source routing bit sends each masked request to either the critical or the non-critical output of that instance. Both outputs are registered.

A further instance acts as the root. The non-critical output of child `i` drives source `i` of the root. The root's non-critical output is the block's main interrupt line. The block's critical line is the OR of the registered critical outputs of all instances. A combinational vector encoder names the pending interrupt, or reports that none is pending. To service an interrupt, software clears the child's status bit first and then the root's cascade bit.

All registers of all instances sit on one simple bus. The upper address bits select the instance: children are `0..NCHILD-1` and the root is `NCHILD`. The low three bits select the register. Reads come back registered.

Top module: `intc_cascade`

## Requirements
- R1: Source `n` of an instance occupies register bit `NSRC-1-n` in every per-source register, so source 0 is the MSB. On the flat input `src_in`, child `i` source `n` is bit `i*NSRC+n`.
- R2: The status register has address code 0. It is sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A level-mode source that is still active sets its bit again on the cycle after the clear.
- R3: The masked-status register has code 5 and is read-only. It reads as status AND enable (enable is code 1). Writes to code 5 change no register.
- R4: The trigger register has code 4. A bit value of 0 selects level mode. A bit value of 1 selects edge mode, in which the bit is set only on an active transition of the synchronized input, and holding the input active does not set it again.
- R5: The polarity register has code 3. A bit value of 1 makes a high level (or rising edge) active. A bit value of 0 makes a low level (or falling edge) active.
- R6: The critical register has code 2. Masked bits whose critical bit is 1 drive the critical output, and masked bits whose critical bit is 0 drive the non-critical output. Each output is a registered OR of those bits.
- R7: After reset, the enable, critical, polarity and trigger registers are 0, status is 0, and the outputs are low.
- R8: Read data is the addressed register's value, one clock after the address is presented. An unused register code reads 0.
- R9: If a status clear and a new edge on the same bit fall on the same clock, the bit stays set.
- R10: The non-critical output of child `i` drives root source `i` (root bit `NSRC-1-i`). The root's non-critical output is `irq_nc`.
- R11: The vector encoder examines children in order 0, 1, 2 and so on. It picks the first child whose root masked cascade bit is set and whose own masked status is nonzero. It reports `i*NSRC + (NSRC-1-p)`, where `p` is the lowest set masked bit of that child. When no child qualifies, `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NCHILD*NSRC | Raw interrupt sources, child-major |
| bus_addr | input | AW | Instance select in the upper bits, register code in bits 2:0 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| irq_nc | output | 1 | Non-critical interrupt from the root |
| irq_cr | output | 1 | Critical interrupt from any instance |
| vec_valid | output | 1 | A vector is pending |
| vec_num | output | VW | Pending interrupt number |

## Verification
The assertions check the following on every cycle:
- No status bit ever drops without a matching write-1 clear.
- Each interrupt output equals the OR of the masked and routed bits one clock earlier.
- Any reported vector points at a set root cascade bit and a set child masked bit.
- With no masked cascade bit, no vector is reported.

Other behaviours are timing relations that only the bench's scenarios can show: polarity and trigger combinations, the re-set of a level source after a clear, the collision of a clear with a fresh edge, the child priority order of the vector, the higher-numbered-source rule inside one child, and the propagation through the cascade.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        RG_STAT  = 3'd0,
        RG_EN    = 3'd1,
        RG_CRIT  = 3'd2,
        RG_POL   = 3'd3,
        RG_TRIG  = 3'd4,
        RG_MSTAT = 3'd5
    } reg_code_e;

    localparam int REG_SEL_W = 3;

endpackage

// File: rtl/intc_cond.sv
// Per-source synchronizer, polarity and trigger qualification.
module intc_cond #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] pol,
    input  logic [NSRC-1:0] trig,
    output logic [NSRC-1:0] edge_set,
    output logic [NSRC-1:0] lvl_set
);

    logic [NSRC-1:0] sync1_q;
    logic [NSRC-1:0] sync2_q;
    logic [NSRC-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            hist_q  <= '0;
        end else begin
            sync1_q <= raw;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
        end
    end

    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        logic act_now;
        logic act_old;
        always_comb begin
            act_now     = pol[b] ? sync2_q[b] : ~sync2_q[b];
            act_old     = pol[b] ? hist_q[b]  : ~hist_q[b];
            edge_set[b] = trig[b] & act_now & ~act_old;
            lvl_set[b]  = ~trig[b] & act_now;
        end
    end

endmodule

// File: rtl/intc_core.sv
// One controller instance: registers, status latch, output routing.
module intc_core
    import intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src,
    input  logic                 wr_en,
    input  logic [REG_SEL_W-1:0] sel,
    input  logic [NSRC-1:0]      wdata,
    output logic [NSRC-1:0]      rd_word,
    output logic [NSRC-1:0]      stat_o,
    output logic [NSRC-1:0]      msk_o,
    output logic [NSRC-1:0]      crit_o,
    output logic                 irq_nc,
    output logic                 irq_cr
);

    logic [NSRC-1:0] stat_q, en_q, crit_q, pol_q, trig_q;
    logic [NSRC-1:0] edge_set, lvl_set, clr_mask, stat_nx, msk;
    reg_code_e       code;

    intc_cond #(.NSRC(NSRC)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (src),
        .pol      (pol_q),
        .trig     (trig_q),
        .edge_set (edge_set),
        .lvl_set  (lvl_set)
    );

    always_comb begin
        code     = reg_code_e'(sel);
        clr_mask = (wr_en && code == RG_STAT) ? wdata : '0;
        // edge beats clear, level waits one cycle behind a clear
        stat_nx  = (stat_q & ~clr_mask) | edge_set | (lvl_set & ~clr_mask);
        msk      = stat_q & en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
            crit_q <= '0;
            pol_q  <= '0;
            trig_q <= '0;
            irq_nc <= 1'b0;
            irq_cr <= 1'b0;
        end else begin
            stat_q <= stat_nx;
            irq_nc <= |(msk & ~crit_q);
            irq_cr <= |(msk & crit_q);
            if (wr_en) begin
                unique case (code)
                    RG_EN:   en_q   <= wdata;
                    RG_CRIT: crit_q <= wdata;
                    RG_POL:  pol_q  <= wdata;
                    RG_TRIG: trig_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (code)
            RG_STAT:  rd_word = stat_q;
            RG_EN:    rd_word = en_q;
            RG_CRIT:  rd_word = crit_q;
            RG_POL:   rd_word = pol_q;
            RG_TRIG:  rd_word = trig_q;
            RG_MSTAT: rd_word = msk;
            default:  rd_word = '0;
        endcase
    end

    assign stat_o = stat_q;
    assign msk_o  = msk;
    assign crit_o = crit_q;

endmodule

// File: rtl/intc_vec.sv
// Vector encoder: child priority by index, lowest set bit inside a child.
module intc_vec #(
    parameter int NCHILD = 3,
    parameter int NSRC   = 32,
    parameter int VW     = 7
) (
    input  logic [NCHILD-1:0] casc,
    input  logic [NSRC-1:0]   cmsk [NCHILD],
    output logic              valid,
    output logic [VW-1:0]     num
);

    localparam int PW = $clog2(NSRC);

    logic [PW-1:0] low_pos [NCHILD];
    logic [NCHILD-1:0] hit;

    for (genvar c = 0; c < NCHILD; c++) begin : g_child
        always_comb begin
            low_pos[c] = '0;
            for (int b = NSRC - 1; b >= 0; b--) begin
                if (cmsk[c][b]) low_pos[c] = PW'(b);
            end
            hit[c] = casc[c] & (|cmsk[c]);
        end
    end

    always_comb begin
        valid = 1'b0;
        num   = '0;
        for (int c = NCHILD - 1; c >= 0; c--) begin
            if (hit[c]) begin
                valid = 1'b1;
                num   = VW'(c * NSRC + (NSRC - 1) - int'(low_pos[c]));
            end
        end
    end

endmodule

// File: rtl/intc_cascade.sv
// Top: NCHILD child controllers feeding one root controller.
module intc_cascade
    import intc_pkg::*;
#(
    parameter int NCHILD = 3,
    parameter int NSRC   = 32,
    parameter int AW     = $clog2(NCHILD + 1) + REG_SEL_W,
    parameter int VW     = $clog2(NCHILD * NSRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCHILD*NSRC-1:0]   src_in,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_wr,
    input  logic [NSRC-1:0]          bus_wdata,
    output logic [NSRC-1:0]          bus_rdata,
    output logic                     irq_nc,
    output logic                     irq_cr,
    output logic                     vec_valid,
    output logic [VW-1:0]            vec_num
);

    localparam int NI   = NCHILD + 1;
    localparam int ROOT = NCHILD;
    localparam int IW   = AW - REG_SEL_W;

    logic [NSRC-1:0]      src_a  [NI];
    logic [NSRC-1:0]      rd_a   [NI];
    logic [NSRC-1:0]      stat_a [NI];
    logic [NSRC-1:0]      msk_a  [NI];
    logic [NSRC-1:0]      crit_a [NI];
    logic [NSRC-1:0]      cmsk   [NCHILD];
    logic [NI-1:0]        nc_a, cr_a;
    logic [NCHILD-1:0]    casc;
    logic [IW-1:0]        inst;
    logic [REG_SEL_W-1:0] sel;

    assign inst = bus_addr[AW-1:REG_SEL_W];
    assign sel  = bus_addr[REG_SEL_W-1:0];

    for (genvar i = 0; i < NI; i++) begin : g_inst
        if (i < NCHILD) begin : g_leaf
            for (genvar n = 0; n < NSRC; n++) begin : g_map
                assign src_a[i][NSRC-1-n] = src_in[i*NSRC+n];
            end
            assign cmsk[i] = msk_a[i];
            assign casc[i] = msk_a[ROOT][NSRC-1-i];
        end else begin : g_root
            for (genvar n = 0; n < NSRC; n++) begin : g_map
                if (n < NCHILD) begin : g_cas
                    assign src_a[i][NSRC-1-n] = nc_a[n];
                end else begin : g_tie
                    assign src_a[i][NSRC-1-n] = 1'b0;
                end
            end
        end

        intc_core #(.NSRC(NSRC)) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_a[i]),
            .wr_en   (bus_wr && int'(inst) == i),
            .sel     (sel),
            .wdata   (bus_wdata),
            .rd_word (rd_a[i]),
            .stat_o  (stat_a[i]),
            .msk_o   (msk_a[i]),
            .crit_o  (crit_a[i]),
            .irq_nc  (nc_a[i]),
            .irq_cr  (cr_a[i])
        );
    end

    intc_vec #(.NCHILD(NCHILD), .NSRC(NSRC), .VW(VW)) u_vec (
        .casc  (casc),
        .cmsk  (cmsk),
        .valid (vec_valid),
        .num   (vec_num)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (int'(inst) < NI) begin
            bus_rdata <= rd_a[inst];
        end else begin
            bus_rdata <= '0;
        end
    end

    assign irq_nc = nc_a[ROOT];
    assign irq_cr = |cr_a;

endmodule

// File: rtl/intc_chk.sv
// Checker bound to intc_cascade.
module intc_chk #(
    parameter int NCHILD = 3,
    parameter int NSRC   = 32,
    parameter int AW     = 5,
    parameter int VW     = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic [NSRC-1:0] bus_wdata,
    input logic            irq_nc,
    input logic            irq_cr,
    input logic            vec_valid,
    input logic [VW-1:0]   vec_num,
    input logic [NSRC-1:0] stat_a [NCHILD+1],
    input logic [NSRC-1:0] msk_a  [NCHILD+1],
    input logic [NSRC-1:0] crit_a [NCHILD+1]
);

    localparam int NI   = NCHILD + 1;
    localparam int ROOT = NCHILD;

    logic [NSRC-1:0] clr_a [NI];
    logic            cr_any, nc_root, casc_any, par_ok, child_ok;
    int              vc_child, vc_pos;

    always_comb begin
        cr_any   = 1'b0;
        casc_any = 1'b0;
        for (int i = 0; i < NI; i++) begin
            clr_a[i] = (bus_wr && int'(bus_addr[AW-1:3]) == i && bus_addr[2:0] == 3'd0)
                       ? bus_wdata : '0;
            cr_any   = cr_any | (|(msk_a[i] & crit_a[i]));
        end
        for (int i = 0; i < NCHILD; i++) casc_any = casc_any | msk_a[ROOT][NSRC-1-i];
        nc_root  = |(msk_a[ROOT] & ~crit_a[ROOT]);
        vc_child = int'(vec_num) / NSRC;
        vc_pos   = NSRC - 1 - (int'(vec_num) % NSRC);
        par_ok   = (vc_child < NCHILD) ? msk_a[ROOT][NSRC-1-vc_child] : 1'b0;
        child_ok = (vc_child < NCHILD) ? msk_a[vc_child][vc_pos] : 1'b0;
    end

    for (genvar g = 0; g < NI; g++) begin : g_sticky
        assert_sticky_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((~stat_a[g]) & $past(stat_a[g]) & ~$past(clr_a[g])) == '0)
            else $error("status bit dropped without a clear");
    end

    assert_nc_registered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nc == $past(nc_root))
        else $error("irq_nc mismatch");

    assert_cr_registered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cr == $past(cr_any))
        else $error("irq_cr mismatch");

    assert_vec_root_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (par_ok && child_ok))
        else $error("vector points at an idle bit");

    assert_vec_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_any |-> !vec_valid)
        else $error("vector without cascade request");

endmodule

bind intc_cascade intc_chk #(.NCHILD(NCHILD), .NSRC(NSRC), .AW(AW), .VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_nc    (irq_nc),
    .irq_cr    (irq_cr),
    .vec_valid (vec_valid),
    .vec_num   (vec_num),
    .stat_a    (stat_a),
    .msk_a     (msk_a),
    .crit_a    (crit_a)
);

// File: tb/tb_intc_cascade.sv
`timescale 1ns/1ps
module tb_intc_cascade;

    localparam int NCHILD = 3;
    localparam int NSRC   = 32;
    localparam int AW     = 5;
    localparam int VW     = 7;
    localparam int NI     = NCHILD + 1;
    localparam int ROOT   = NCHILD;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NCHILD*NSRC-1:0] src_in = '0;
    logic [AW-1:0]          bus_addr = '0;
    logic                   bus_wr = 1'b0;
    logic [NSRC-1:0]        bus_wdata = '0;
    logic [NSRC-1:0]        bus_rdata;
    logic                   irq_nc, irq_cr, vec_valid;
    logic [VW-1:0]          vec_num;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    intc_cascade #(.NCHILD(NCHILD), .NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_nc(irq_nc), .irq_cr(irq_cr), .vec_valid(vec_valid), .vec_num(vec_num)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_s1[NI], m_s2[NI], m_s3[NI], m_st[NI];
    logic [31:0] m_en[NI], m_cr[NI], m_po[NI], m_tr[NI];
    logic [31:0] m_raw[NI], m_nst[NI];
    logic        m_nc[NI], m_crq[NI], m_ncn[NI], m_crn[NI];
    logic [31:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NI; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_st[i] = 0;
                m_en[i] = 0; m_cr[i] = 0; m_po[i] = 0; m_tr[i] = 0;
                m_nc[i] = 0; m_crq[i] = 0;
            end
            m_rd = 0;
        end else begin
            int wi, wr_reg;
            wi     = int'(bus_addr) / 8;
            wr_reg = int'(bus_addr) % 8;
            for (int i = 0; i < NI; i++) begin
                for (int n = 0; n < 32; n++) begin
                    bit a, ap, clr;
                    if (i < NCHILD) m_raw[i][31-n] = src_in[i*32+n];
                    else            m_raw[i][31-n] = (n < NCHILD) ? m_nc[n] : 1'b0;
                    a   = m_po[i][31-n] ? m_s2[i][31-n] : !m_s2[i][31-n];
                    ap  = m_po[i][31-n] ? m_s3[i][31-n] : !m_s3[i][31-n];
                    clr = bus_wr && wi == i && wr_reg == 0 && bus_wdata[31-n];
                    if (m_tr[i][31-n]) m_nst[i][31-n] = (a && !ap) || (m_st[i][31-n] && !clr);
                    else               m_nst[i][31-n] = (a || m_st[i][31-n]) && !clr;
                end
                m_ncn[i] = |(m_st[i] & m_en[i] & ~m_cr[i]);
                m_crn[i] = |(m_st[i] & m_en[i] & m_cr[i]);
            end
            if (wi < NI) begin
                case (wr_reg)
                    0: m_rd = m_st[wi];
                    1: m_rd = m_en[wi];
                    2: m_rd = m_cr[wi];
                    3: m_rd = m_po[wi];
                    4: m_rd = m_tr[wi];
                    5: m_rd = m_st[wi] & m_en[wi];
                    default: m_rd = 0;
                endcase
            end else m_rd = 0;
            for (int i = 0; i < NI; i++) begin
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = m_raw[i];
                m_st[i] = m_nst[i]; m_nc[i] = m_ncn[i]; m_crq[i] = m_crn[i];
            end
            if (bus_wr && wi < NI) begin
                case (wr_reg)
                    1: m_en[wi] = bus_wdata;
                    2: m_cr[wi] = bus_wdata;
                    3: m_po[wi] = bus_wdata;
                    4: m_tr[wi] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic void model_vec(output bit v, output int num);
        v = 0; num = 0;
        for (int c = 0; c < NCHILD; c++) begin
            logic [31:0] cm;
            cm = m_st[c] & m_en[c];
            if (!v && (m_st[ROOT][31-c] && m_en[ROOT][31-c]) && cm != 0) begin
                for (int b = 31; b >= 0; b--) if (cm[b]) num = c * 32 + 31 - b;
                v = 1;
            end
        end
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit v; int num; bit crx;
            model_vec(v, num);
            crx = 0;
            for (int i = 0; i < NI; i++) crx |= m_crq[i];
            check(irq_nc == m_nc[ROOT], "R6 irq_nc per-cycle", irq_nc, m_nc[ROOT]);
            check(irq_cr == crx, "R6 irq_cr per-cycle", irq_cr, crx);
            check(vec_valid == v, "R11 vec_valid per-cycle", vec_valid, v);
            if (v) check(int'(vec_num) == num, "R11 vec_num per-cycle", vec_num, num);
            check(bus_rdata == m_rd, "R8 rdata per-cycle", bus_rdata, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int inst, input int r, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(inst * 8 + r);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int inst, input int r, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = AW'(inst * 8 + r);
        @(negedge clk);
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R7 reset state
        check(irq_nc == 0 && irq_cr == 0, "R7 outputs after reset", {irq_nc, irq_cr}, 0);
        check(vec_valid == 0, "R7 no vector after reset", vec_valid, 0);
        rd(0, 1, 32'h0, "R7 enable reset R8");
        rd(1, 2, 32'h0, "R7 critical reset");
        rd(2, 3, 32'h0, "R7 polarity reset");
        rd(ROOT, 4, 32'h0, "R7 trigger reset");
        // R5: polarity 0 with low inputs is active, level latches everything
        rd(0, 0, 32'hFFFF_FFFF, "R5 active-low level latch");
        rd(0, 6, 32'h0, "R8 unused code reads zero");

        for (int i = 0; i < NI; i++) wr(i, 3, 32'hFFFF_FFFF);
        for (int i = 0; i < NI; i++) wr(i, 0, 32'hFFFF_FFFF);
        idle(6);
        for (int i = 0; i < NI; i++) wr(i, 0, 32'hFFFF_FFFF);
        idle(6);
        rd(0, 0, 32'h0, "R2 clear all");

        // R1 bit mapping
        src_in[5] = 1'b1;
        idle(5);
        rd(0, 0, 32'h0400_0000, "R1 source 5 at bit 26");
        // R2 level re-set after clear
        wr(0, 0, 32'h0400_0000);
        rd(0, 0, 32'h0400_0000, "R2 level source sets again");
        src_in[5] = 1'b0;
        idle(5);
        wr(0, 0, 32'h0400_0000);
        rd(0, 0, 32'h0, "R2 cleared after source drops");

        // R3 masked status, read-only
        src_in[5] = 1'b1;
        idle(5);
        wr(0, 1, 32'h0400_0001);
        rd(0, 5, 32'h0400_0000, "R3 masked equals status and enable");
        wr(0, 5, 32'hFFFF_FFFF);
        rd(0, 1, 32'h0400_0001, "R3 write to masked leaves enable");
        rd(0, 0, 32'h0400_0000, "R3 write to masked leaves status");

        // R6 routing
        idle(3);
        check(irq_nc == 0, "R6 root disabled keeps irq_nc low", irq_nc, 0);
        wr(0, 2, 32'h0400_0000);
        idle(3);
        check(irq_cr == 1, "R6 critical routing", irq_cr, 1);
        wr(0, 2, 32'h0);
        idle(3);
        check(irq_cr == 0, "R6 critical off", irq_cr, 0);

        src_in[5] = 1'b0;
        idle(5);
        wr(0, 0, 32'hFFFF_FFFF);
        idle(8);
        wr(ROOT, 0, 32'hFFFF_FFFF);
        idle(3);

        // R4 edge mode
        wr(0, 4, 32'h0100_0000);
        src_in[7] = 1'b1;
        idle(5);
        rd(0, 0, 32'h0100_0000, "R4 rising edge sets");
        wr(0, 0, 32'h0100_0000);
        idle(4);
        rd(0, 0, 32'h0, "R4 held edge input does not re-set");
        src_in[7] = 1'b0;

        // R5 falling edge
        wr(0, 4, 32'h0180_0000);
        wr(0, 3, ~32'h0080_0000);
        src_in[8] = 1'b1;
        idle(5);
        rd(0, 0, 32'h0, "R5 rising ignored with polarity 0");
        src_in[8] = 1'b0;
        idle(5);
        rd(0, 0, 32'h0080_0000, "R5 falling edge sets");
        wr(0, 0, 32'hFFFF_FFFF);

        // R9 clear and edge in the same cycle
        src_in[7] = 1'b1;
        idle(5);
        src_in[7] = 1'b0;
        idle(5);
        @(negedge clk);
        src_in[7] = 1'b1;
        @(negedge clk);
        wr(0, 0, 32'h0100_0000);
        rd(0, 0, 32'h0100_0000, "R9 edge wins over clear");
        src_in[7] = 1'b0;
        wr(0, 0, 32'hFFFF_FFFF);

        // R10 / R11 cascade and vector
        wr(ROOT, 1, 32'hE000_0000);
        wr(1, 1, 32'h1000_0000);
        src_in[32+3] = 1'b1;
        idle(12);
        check(irq_nc == 1, "R10 child reaches root output", irq_nc, 1);
        check(vec_valid && vec_num == 35, "R11 vector child1 source3", vec_num, 35);
        wr(0, 1, 32'h0020_0000);
        src_in[10] = 1'b1;
        idle(12);
        check(vec_valid && vec_num == 10, "R11 child0 has priority", vec_num, 10);
        src_in[10] = 1'b0;
        idle(5);
        wr(0, 0, 32'hFFFF_FFFF);
        wr(1, 1, 32'h1040_0000);
        src_in[32+9] = 1'b1;
        idle(12);
        check(vec_valid && vec_num == 41, "R11 lowest set bit wins in child", vec_num, 41);
        src_in[32+9] = 1'b0;
        src_in[32+3] = 1'b0;
        idle(5);
        for (int i = 0; i < NCHILD; i++) wr(i, 0, 32'hFFFF_FFFF);
        idle(8);
        wr(ROOT, 0, 32'hFFFF_FFFF);
        idle(4);
        check(vec_valid == 0, "R11 none pending", vec_valid, 0);
        check(irq_nc == 0, "R10 root output idle", irq_nc, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule